// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block runs on the host side of a parallel flash and decides when a program or erase the host has just issued is finished. After a start pulse it arms itself, counts the host's write strobes until the last strobe of the command sequence has gone out, and then watches the device. The host picks one of three ways to watch. The first checks the polarity of status bit 7. The second looks for status bit 6 to stop alternating between reads. The third waits for the device's ready line. Reads go through a simple request/acknowledge port aimed at the location being written.

A status read can land at the same moment the device finishes, so the first completion the block sees is treated only as a hint. After that hint the block reads the same location twice more. Only when both reads return the expected final contents does it pulse `done`. If either read is wrong it pulses `fail`. When no completion is seen within a host-set number of polls it pulses `timeout`. It then returns to idle, ready for the next start.

Top module: `flash_done_poller`

## Requirements
- R1: A `start` pulse is taken only while `busy` is low. It captures `op_erase`, `mode`, `expect_data` and `poll_limit`, and `busy` is high from the next cycle. A `start` while `busy` is high is ignored and leaves the captured values unchanged.
- R2: Neither reads nor ready-line waiting begin until `wr_strobe` has pulsed 4 times after the start for a program (`op_erase`=0), or 6 times for an erase (`op_erase`=1).
- R3: `rd_req` stays high until a cycle in which `rd_ack` is high. `rd_data` is taken in that cycle and the read ends there.
- R4: In mode 0 (and the reserved mode 3), a status read shows apparent completion for a program when `rd_data[7]` equals `expect_data[7]`, and for an erase when `rd_data[7]` is 1.
- R5: In mode 1, a status read shows apparent completion when its bit 6 equals bit 6 of the previous status read of the same operation. The first status read never does.
- R6: In mode 2, `ready_in` (high = ready) is resampled through a two-flop synchronizer. No status reads are issued, and apparent completion is the synchronized level being high.
- R7: After apparent completion, exactly two more reads are made. A read is valid when the whole word equals `expect_data` (program) or all ones (erase). The first invalid read ends the operation with `fail` right after that read. Two valid reads end it with `done`.
- R8: Status evaluations that show no completion are counted: reads in modes 0, 1 and 3, and clock cycles in mode 2. `timeout` fires on the evaluation whose count reaches `poll_limit`, with a limit of 0 handled as 1.
- R9: `done`, `fail` and `timeout` are one-cycle pulses that never overlap. Each is high in the cycle after the deciding acknowledge or evaluation, and `busy` is already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin tracking one operation |
| op_erase | input | 1 | 0 = program, 1 = erase |
| mode | input | 2 | 0 bit-7 polarity, 1 bit-6 toggle, 2 ready line, 3 as 0 |
| expect_data | input | DATA_W | Word that was programmed |
| poll_limit | input | CNT_W | Maximum evaluations before timeout |
| wr_strobe | input | 1 | One pulse per command write strobe |
| ready_in | input | 1 | Device ready line, asynchronous |
| rd_req | output | 1 | Read request to the accessed location |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | DATA_W | Read data |
| busy | output | 1 | Operation being tracked |
| done | output | 1 | Completion confirmed |
| fail | output | 1 | Confirmation read mismatch |
| timeout | output | 1 | Poll limit reached |

## Verification
The bench's device model answers a request with an acknowledge one cycle later and leaves one idle cycle between acknowledges. As a result, in modes 0, 1 and 3 the result pulse must appear on the (2·R+1)-th falling edge after the final strobe is driven, where R is the number of reads the bench predicts. The bench checks both that edge and R itself. In mode 2, with the block already waiting, `done` is due 7 falling edges after `ready_in` rises (two synchronizer cycles, one decision cycle, two reads), and a timeout is due poll_limit+1 falling edges after the final strobe. Every check samples on the falling edge, and the cycle after each pulse is checked for an idle, quiet output.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARM     = 3'd1,
        ST_READ    = 3'd2,
        ST_WAIT_RB = 3'd3,
        ST_CONF    = 3'd4
    } fdp_state_e;

    localparam logic [1:0] MODE_DATA   = 2'd0;
    localparam logic [1:0] MODE_TOGGLE = 2'd1;
    localparam logic [1:0] MODE_RDY    = 2'd2;
endpackage

// File: rtl/fdp_sync.sv
module fdp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= 1'b0;
                end else begin
                    chain_q[g] <= (g == 0) ? din : chain_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/fdp_eval.sv
module fdp_eval #(
    parameter int DATA_W     = 16,
    parameter int POLAR_BIT  = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  logic [1:0]        mode,
    input  logic              erase,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] expect_w,
    input  logic              prev_tb,
    input  logic              have_prev,
    output logic              looks_done,
    output logic              data_ok
);
    import fdp_pkg::*;

    always_comb begin
        data_ok = erase ? (&data) : (data == expect_w);
        unique case (mode)
            MODE_TOGGLE: looks_done = have_prev && (data[TOGGLE_BIT] == prev_tb);
            MODE_RDY:    looks_done = 1'b0;
            default:     looks_done = erase ? data[POLAR_BIT]
                                            : (data[POLAR_BIT] == expect_w[POLAR_BIT]);
        endcase
    end
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
    parameter int DATA_W        = 16,
    parameter int CNT_W         = 16,
    parameter int PROG_STROBES  = 4,
    parameter int ERASE_STROBES = 6,
    parameter int SYNC_STAGES   = 2,
    parameter int POLAR_BIT     = 7,
    parameter int TOGGLE_BIT    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_erase,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] expect_data,
    input  logic [CNT_W-1:0]  poll_limit,
    input  logic              wr_strobe,
    input  logic              ready_in,
    output logic              rd_req,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              timeout
);
    import fdp_pkg::*;

    localparam int STB_MAX = (PROG_STROBES > ERASE_STROBES) ? PROG_STROBES : ERASE_STROBES;
    localparam int STB_W   = $clog2(STB_MAX + 1);
    localparam logic [STB_W-1:0] PROG_LAST  = STB_W'(PROG_STROBES - 1);
    localparam logic [STB_W-1:0] ERASE_LAST = STB_W'(ERASE_STROBES - 1);

    typedef struct packed {
        fdp_state_e        state;
        logic              erase;
        logic [1:0]        mode;
        logic [DATA_W-1:0] expect_w;
        logic [CNT_W-1:0]  limit;
        logic [CNT_W-1:0]  cnt;
        logic [STB_W-1:0]  stb;
        logic              prev_tb;
        logic              have_prev;
        logic              conf_second;
        logic              done;
        logic              fail;
        logic              tmo;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic             ready_s;
    logic             looks_done;
    logic             data_ok;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W:0]   eff_limit;
    logic             expired;
    logic [STB_W-1:0] stb_last;

    fdp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ready_in),
        .dout  (ready_s)
    );

    fdp_eval #(
        .DATA_W     (DATA_W),
        .POLAR_BIT  (POLAR_BIT),
        .TOGGLE_BIT (TOGGLE_BIT)
    ) u_eval (
        .mode       (ctx_q.mode),
        .erase      (ctx_q.erase),
        .data       (rd_data),
        .expect_w   (ctx_q.expect_w),
        .prev_tb    (ctx_q.prev_tb),
        .have_prev  (ctx_q.have_prev),
        .looks_done (looks_done),
        .data_ok    (data_ok)
    );

    always_comb begin
        cnt_inc   = {1'b0, ctx_q.cnt} + 1'b1;
        eff_limit = (ctx_q.limit == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, ctx_q.limit};
        expired   = (cnt_inc >= eff_limit);
        stb_last  = ctx_q.erase ? ERASE_LAST : PROG_LAST;

        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        ctx_d.fail = 1'b0;
        ctx_d.tmo  = 1'b0;

        unique case (ctx_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctx_d.state       = ST_ARM;
                    ctx_d.erase       = op_erase;
                    ctx_d.mode        = mode;
                    ctx_d.expect_w    = expect_data;
                    ctx_d.limit       = poll_limit;
                    ctx_d.cnt         = '0;
                    ctx_d.stb         = '0;
                    ctx_d.have_prev   = 1'b0;
                    ctx_d.conf_second = 1'b0;
                end
            end
            ST_ARM: begin
                if (wr_strobe) begin
                    if (ctx_q.stb == stb_last) begin
                        ctx_d.state = (ctx_q.mode == MODE_RDY) ? ST_WAIT_RB : ST_READ;
                    end else begin
                        ctx_d.stb = ctx_q.stb + 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (rd_ack) begin
                    ctx_d.prev_tb   = rd_data[TOGGLE_BIT];
                    ctx_d.have_prev = 1'b1;
                    if (looks_done) begin
                        ctx_d.state = ST_CONF;
                    end else if (expired) begin
                        ctx_d.state = ST_IDLE;
                        ctx_d.tmo   = 1'b1;
                    end else begin
                        ctx_d.cnt = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            ST_WAIT_RB: begin
                if (ready_s) begin
                    ctx_d.state = ST_CONF;
                end else if (expired) begin
                    ctx_d.state = ST_IDLE;
                    ctx_d.tmo   = 1'b1;
                end else begin
                    ctx_d.cnt = cnt_inc[CNT_W-1:0];
                end
            end
            ST_CONF: begin
                if (rd_ack) begin
                    if (!data_ok) begin
                        ctx_d.state = ST_IDLE;
                        ctx_d.fail  = 1'b1;
                    end else if (ctx_q.conf_second) begin
                        ctx_d.state = ST_IDLE;
                        ctx_d.done  = 1'b1;
                    end else begin
                        ctx_d.conf_second = 1'b1;
                    end
                end
            end
            default: ctx_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign rd_req  = (ctx_q.state == ST_READ) || (ctx_q.state == ST_CONF);
    assign busy    = (ctx_q.state != ST_IDLE);
    assign done    = ctx_q.done;
    assign fail    = ctx_q.fail;
    assign timeout = ctx_q.tmo;
endmodule

// File: rtl/fdp_checker.sv
module fdp_checker #(
    parameter int PROG_STROBES  = 4,
    parameter int ERASE_STROBES = 6
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic op_erase,
    input logic wr_strobe,
    input logic busy,
    input logic rd_req,
    input logic rd_ack,
    input logic done,
    input logic fail,
    input logic timeout
);
    logic [3:0] seen_q;
    logic [3:0] need_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
            need_q <= '0;
        end else if (start && !busy) begin
            seen_q <= '0;
            need_q <= op_erase ? 4'(ERASE_STROBES) : 4'(PROG_STROBES);
        end else if (busy && wr_strobe && seen_q != 4'hF) begin
            seen_q <= seen_q + 4'd1;
        end
    end

    assert_start_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_req_in_op_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

    assert_no_early_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (seen_q >= need_q));

    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req);

    assert_one_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fail, timeout}));

    assert_result_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail || timeout) |=> !(done || fail || timeout));

    assert_idle_at_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail || timeout) |-> !busy);
endmodule

bind flash_done_poller fdp_checker #(
    .PROG_STROBES  (PROG_STROBES),
    .ERASE_STROBES (ERASE_STROBES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_erase  (op_erase),
    .wr_strobe (wr_strobe),
    .busy      (busy),
    .rd_req    (rd_req),
    .rd_ack    (rd_ack),
    .done      (done),
    .fail      (fail),
    .timeout   (timeout)
);

// File: tb/sim_flash_done_poller.sv
`timescale 1ns/1ps
module sim_flash_done_poller;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_erase = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] expect_data = '0;
    logic [15:0] poll_limit = '0;
    logic        wr_strobe = 1'b0;
    logic        ready_in = 1'b0;
    logic        rd_req;
    logic        rd_ack;
    logic [15:0] rd_data;
    logic        busy, done, fail, timeout;

    int errors = 0;
    int checks = 0;

    int          read_idx;
    int          base_idx = 0;
    int          m_busy = 0;
    int          m_bad_at = -1;
    logic        m_erase = 1'b0;
    logic [15:0] m_exp = '0;

    always #2.5 clk = ~clk;

    flash_done_poller u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase), .mode(mode),
        .expect_data(expect_data), .poll_limit(poll_limit), .wr_strobe(wr_strobe),
        .ready_in(ready_in), .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .done(done), .fail(fail), .timeout(timeout)
    );

    function automatic logic [15:0] gen_word(int i);
        logic [15:0] t, w;
        t = m_erase ? 16'hFFFF : m_exp;
        if (i == m_bad_at) return t ^ 16'h0001;
        if (i <= m_busy) begin
            w = t;
            w[7] = m_erase ? 1'b0 : ~m_exp[7];
            w[6] = i[0];
            return w;
        end
        return t;
    endfunction

    // device model: acknowledge one cycle after a request, idle cycle between acks
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ack   <= 1'b0;
            rd_data  <= '0;
            read_idx <= 0;
        end else if (rd_req && !rd_ack) begin
            rd_ack   <= 1'b1;
            rd_data  <= gen_word(read_idx - base_idx + 1);
            read_idx <= read_idx + 1;
        end else begin
            rd_ack <= 1'b0;
        end
    end

    function automatic int app_idx(int md, bit er, logic [15:0] ex, int nb);
        logic p, c;
        if (md != 1) return nb + 1;
        p = (1 <= nb) ? 1'b1 : (er ? 1'b1 : ex[6]);
        for (int i = 2; i < 64; i++) begin
            c = (i <= nb) ? i[0] : (er ? 1'b1 : ex[6]);
            if (c == p) return i;
            p = c;
        end
        return 64;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic launch(input bit er, input logic [1:0] md, input logic [15:0] ex, input int li);
        int need;
        bit early;
        base_idx = read_idx;
        early = 1'b0;
        @(negedge clk);
        start = 1'b1; op_erase = er; mode = md; expect_data = ex; poll_limit = 16'(li);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
        need = er ? 6 : 4;
        for (int s = 1; s <= need; s++) begin
            repeat (2) begin
                @(negedge clk);
                early |= rd_req;
            end
            wr_strobe = 1'b1;
            if (s < need) begin
                @(negedge clk);
                early |= rd_req;
                wr_strobe = 1'b0;
            end
        end
        chk(!early, "R2 read before final strobe", int'(early), 0);
    endtask

    task automatic wait_result(output int kind, output int lat, input bit inject);
        logic keep_op;
        logic [15:0] keep_ex;
        keep_op = op_erase; keep_ex = expect_data;
        kind = 0; lat = 0;
        for (int c = 1; c <= 300; c++) begin
            @(negedge clk);
            wr_strobe = 1'b0;
            lat = c;
            if (inject && c == 3) begin
                start = 1'b1; op_erase = ~keep_op; expect_data = ~keep_ex;
            end else begin
                start = 1'b0;
            end
            if (done) kind = 1;
            else if (fail) kind = 2;
            else if (timeout) kind = 3;
            if (kind != 0) break;
        end
        start = 1'b0; op_erase = keep_op; expect_data = keep_ex;
        @(negedge clk);
        chk(!done && !fail && !timeout && !busy, "R9 single pulse then idle",
            int'({busy, done, fail, timeout}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int kind, lat, a, t, rexp, kexp, idx, reads;
        int lims[4];
        lims = '{0, 2, 3, 8};
        idx = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !rd_req && !done && !fail && !timeout, "R9 reset state",
            int'({busy, rd_req, done, fail, timeout}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // modes 0, 1, 3: polarity / toggle sweeps (R3 R4 R5 R7 R8)
        for (int md = 0; md < 4; md++) begin
            if (md == 2) continue;
            for (int er = 0; er < 2; er++)
                for (int nb = 0; nb < 5; nb++)
                    for (int li = 0; li < 4; li++)
                        for (int bad = 0; bad < 3; bad++) begin
                            logic [15:0] ex;
                            string tag;
                            idx++;
                            ex = 16'h3C5A ^ 16'(idx * 16'h2B71);
                            a = app_idx(md, er[0], ex, nb);
                            t = (lims[li] == 0) ? 1 : lims[li];
                            if (t < a) begin
                                kexp = 3; rexp = t; tag = "R8 timeout";
                            end else if (bad != 0) begin
                                kexp = 2; rexp = a + bad; tag = "R7 confirm fail";
                            end else begin
                                kexp = 1; rexp = a + 2;
                                tag = (md == 1) ? "R5 toggle done" : "R4 polarity done";
                            end
                            m_erase = er[0]; m_exp = ex; m_busy = nb;
                            m_bad_at = (bad != 0) ? a + bad : -1;
                            launch(er[0], 2'(md), ex, lims[li]);
                            wait_result(kind, lat, (rexp >= 3) && (idx % 7 == 0));
                            reads = read_idx - base_idx;
                            chk(kind == kexp, tag, kind, kexp);
                            chk(reads == rexp, "R7 read count", reads, rexp);
                            chk(lat == 2 * rexp + 1, "R3 result cycle", lat, 2 * rexp + 1);
                        end
        end

        // mode 2: ready line (R6 R7)
        for (int er = 0; er < 2; er++)
            for (int bad = 0; bad < 3; bad++)
                for (int d = 1; d < 4; d += 2) begin
                    bit early;
                    m_erase = er[0]; m_exp = 16'h5AC3; m_busy = 0;
                    m_bad_at = (bad != 0) ? bad : -1;
                    ready_in = 1'b0;
                    launch(er[0], 2'd2, 16'h5AC3, 200);
                    early = 1'b0;
                    for (int w = 0; w < d; w++) begin
                        @(negedge clk);
                        wr_strobe = 1'b0;
                        early |= rd_req;
                    end
                    chk(!early, "R6 no reads while busy line low", int'(early), 0);
                    ready_in = 1'b1;
                    wait_result(kind, lat, 1'b0);
                    reads = read_idx - base_idx;
                    kexp = (bad == 0) ? 1 : 2;
                    rexp = (bad == 0) ? 2 : bad;
                    chk(kind == kexp, "R6 ready result", kind, kexp);
                    chk(reads == rexp, "R7 ready confirm reads", reads, rexp);
                    chk(lat == 2 * rexp + 3, "R6 sync latency", lat, 2 * rexp + 3);
                    ready_in = 1'b0;
                    repeat (4) @(negedge clk);
                end

        // mode 2 timeout (R8)
        for (int k = 0; k < 4; k++) begin
            int lv;
            lv = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 4 : 9;
            m_bad_at = -1;
            launch(1'b0, 2'd2, 16'h1234, lv);
            wait_result(kind, lat, 1'b0);
            reads = read_idx - base_idx;
            t = (lv == 0) ? 1 : lv;
            chk(kind == 3, "R8 ready timeout", kind, 3);
            chk(lat == t + 1, "R8 timeout cycle", lat, t + 1);
            chk(reads == 0, "R6 no reads on timeout", reads, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule